// File: doc/BRIEF.md
# Port-Aware Low-Power Sleep Controller

This block decides the power state of a multi-port serial-bus physical layer. It looks at the host device power state, the two-bit state of every port, a port interrupt enable and a link request to stay powered. When the host sits in a deep power state and no port is in use, it gates off the clock generator and the core references. It then settles in one of two sleep tiers. In the shallow tier, the detect references stay on for every port that could still raise an event. In the deeper tier, every reference is off and only the link request can wake the block.

On wake, the clock generator and all references are switched back on at once. A counter on the always-on slow clock times the restart interval, and a ready flag rises when it runs out. A wake caused by a port gives the link layer a one-cycle notify pulse, together with a vector that names the port or ports that caused it. Once the wake is complete, the block checks again from its active state whether it may sleep.

Top module: `phy_sleep_ctrl`

## Requirements
- R1: Sleep is entered only while dev_pstate is 2'b10 or 2'b11 (D2/D3); with 2'b00 or 2'b01 the block stays active whatever the ports do.
- R2: Sleep is entered only when every port is inactive, where port state 2'b00 means in use and 2'b01 disconnected, 2'b10 disabled and 2'b11 suspended count as inactive; one port at 2'b00 keeps the block active.
- R3: On entry, the deep tier is chosen when no port is suspended and port_int_en is 0, and the shallow tier otherwise. In the shallow tier ref_detect_en[i] is 1 exactly for the ports whose state is not 2'b10; in the deep tier ref_detect_en is all zero.
- R4: In either sleep tier clkgen_en, ref_core_en and clk_ready are 0; in the active state all enables, clk_ready and every ref_detect_en bit are 1.
- R5: lps_req at 1 wakes the block from either tier at the next clock and raises no notify pulse. While lps_req is 1 the active state does not enter sleep.
- R6: In the shallow tier, the port events that wake are bias_evt or disc_evt on a suspended port and conn_evt on a port that is not disabled. Any other event leaves the block asleep.
- R7: In the deep tier all port events are ignored; only lps_req wakes.
- R8: While waking, clkgen_en, ref_core_en and all ref_detect_en bits are 1 and clk_ready is 0. clk_ready rises exactly WAKE_CYCLES clocks after the wake begins.
- R9: A port-event wake makes wake_notify 1 for exactly the first waking cycle, with wake_port holding the qualifying events of that clock; at all other times wake_notify and wake_port are 0.
- R10: A wake always runs to completion even if the sleep conditions still hold. Entry is then checked again from the active state, so sleep resumes one clock after clk_ready rises.
- R11: While reset is asserted the block is active, with all enables and clk_ready at 1 and wake_notify and wake_port at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_pstate | input | 2 | Host device power state, 00..11 for D0..D3 |
| port_state | input | 2*NUM_PORTS | Per-port state, port i in bits [2i+1:2i] |
| port_int_en | input | 1 | Port interrupt enable |
| lps_req | input | 1 | Link request to keep or bring the layer powered |
| bias_evt | input | NUM_PORTS | Incoming bias detected, per port |
| disc_evt | input | NUM_PORTS | Disconnection detected, per port |
| conn_evt | input | NUM_PORTS | New connection detected, per port |
| clkgen_en | output | 1 | Clock generator enable |
| ref_core_en | output | 1 | Enable for the references not needed for detection |
| ref_detect_en | output | NUM_PORTS | Per-port detect reference enable |
| clk_ready | output | 1 | Clock good, layer operational |
| wake_notify | output | 1 | One-cycle pulse on a port-event wake |
| wake_port | output | NUM_PORTS | Ports that caused the wake, valid with wake_notify |

## Verification
The state moves at the clock edge that follows the inputs, so a sleep entry or a wake shows on the enables and on wake_notify one clock after the stimulus. clk_ready rises WAKE_CYCLES clocks after the wake begins. ref_detect_en follows port_state combinationally while in the shallow tier. The bench drives inputs on the falling edge and samples every output at the next falling edge, half a period after the edge that took the inputs. A bench model advances once per rising edge, so each comparison expects the state of exactly one edge later.

// File: rtl/phy_sleep_pkg.sv
package phy_sleep_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_LOW    = 2'd1,
    ST_ULTRA  = 2'd2,
    ST_WAKE   = 2'd3
  } pwr_st_e;

  localparam logic [1:0] PS_INUSE = 2'b00;
  localparam logic [1:0] PS_DISC  = 2'b01;
  localparam logic [1:0] PS_DIS   = 2'b10;
  localparam logic [1:0] PS_SUSP  = 2'b11;

  localparam logic [1:0] DEV_D2 = 2'b10;
  localparam logic [1:0] DEV_D3 = 2'b11;

endpackage

// File: rtl/phy_port_eval.sv
module phy_port_eval
  import phy_sleep_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic [2*NUM_PORTS-1:0] port_state,
  input  logic [NUM_PORTS-1:0]   bias_evt,
  input  logic [NUM_PORTS-1:0]   disc_evt,
  input  logic [NUM_PORTS-1:0]   conn_evt,
  output logic [NUM_PORTS-1:0]   idle_v,
  output logic [NUM_PORTS-1:0]   susp_v,
  output logic [NUM_PORTS-1:0]   need_det_v,
  output logic [NUM_PORTS-1:0]   wake_evt_v
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [1:0] ps;
    assign ps            = port_state[2*i +: 2];
    assign idle_v[i]     = (ps != PS_INUSE);
    assign susp_v[i]     = (ps == PS_SUSP);
    assign need_det_v[i] = (ps != PS_DIS);
    assign wake_evt_v[i] = ((ps == PS_SUSP) && (bias_evt[i] || disc_evt[i]))
                         || ((ps != PS_DIS) && conn_evt[i]);
  end

endmodule

// File: rtl/phy_wake_timer.sv
module phy_wake_timer #(
  parameter int WAKE_CYCLES = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = run || (cnt_q != '0);
  assign done   = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/phy_sleep_fsm.sv
module phy_sleep_fsm
  import phy_sleep_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           dev_pstate,
  input  logic                 all_idle,
  input  logic                 any_susp,
  input  logic                 port_int_en,
  input  logic                 lps_req,
  input  logic [NUM_PORTS-1:0] wake_evt_v,
  input  logic                 timer_done,
  output pwr_st_e              st_q,
  output logic                 wake_notify,
  output logic [NUM_PORTS-1:0] wake_port
);

  pwr_st_e              st_d;
  logic                 ntf_d;
  logic [NUM_PORTS-1:0] port_d;
  logic                 deep_pstate;
  logic                 may_sleep;

  assign deep_pstate = (dev_pstate == DEV_D2) || (dev_pstate == DEV_D3);
  assign may_sleep   = deep_pstate && all_idle && !lps_req;

  always_comb begin
    st_d   = st_q;
    ntf_d  = 1'b0;
    port_d = '0;
    unique case (st_q)
      ST_ACTIVE: if (may_sleep) st_d = (!any_susp && !port_int_en) ? ST_ULTRA : ST_LOW;
      ST_LOW: begin
        if (lps_req || (|wake_evt_v)) st_d = ST_WAKE;
        ntf_d  = |wake_evt_v;
        port_d = wake_evt_v;
      end
      ST_ULTRA:  if (lps_req) st_d = ST_WAKE;
      ST_WAKE:   if (timer_done) st_d = ST_ACTIVE;
      default:   st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_ACTIVE;
      wake_notify <= 1'b0;
      wake_port   <= '0;
    end else begin
      st_q        <= st_d;
      wake_notify <= ntf_d;
      wake_port   <= port_d;
    end
  end

  // R1
  pstate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && !dev_pstate[1]) |=> (st_q == ST_ACTIVE));
  // R2
  port_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && !all_idle) |=> (st_q == ST_ACTIVE));
  // R5
  lps_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_LOW || st_q == ST_ULTRA) && lps_req) |=> (st_q == ST_WAKE));
  // R7
  ultra_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ULTRA && !lps_req) |=> (st_q == ST_ULTRA));
  // R9
  notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_notify |-> ($past(st_q) == ST_LOW && st_q == ST_WAKE && wake_port != '0));
  // R9
  port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_notify |-> (wake_port == '0));

endmodule

// File: rtl/phy_sleep_ctrl.sv
module phy_sleep_ctrl
  import phy_sleep_pkg::*;
#(
  parameter int NUM_PORTS   = 3,
  parameter int WAKE_CYCLES = 66
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             dev_pstate,
  input  logic [2*NUM_PORTS-1:0] port_state,
  input  logic                   port_int_en,
  input  logic                   lps_req,
  input  logic [NUM_PORTS-1:0]   bias_evt,
  input  logic [NUM_PORTS-1:0]   disc_evt,
  input  logic [NUM_PORTS-1:0]   conn_evt,
  output logic                   clkgen_en,
  output logic                   ref_core_en,
  output logic [NUM_PORTS-1:0]   ref_detect_en,
  output logic                   clk_ready,
  output logic                   wake_notify,
  output logic [NUM_PORTS-1:0]   wake_port
);

  localparam int CW = $clog2(WAKE_CYCLES + 1);

  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  logic [NUM_PORTS-1:0] idle_v, susp_v, need_det_v, wake_evt_v;
  logic                 timer_done;
  pwr_st_e              st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phy_port_eval #(.NUM_PORTS(NUM_PORTS)) u_eval (
    .port_state (port_state),
    .bias_evt   (bias_evt),
    .disc_evt   (disc_evt),
    .conn_evt   (conn_evt),
    .idle_v     (idle_v),
    .susp_v     (susp_v),
    .need_det_v (need_det_v),
    .wake_evt_v (wake_evt_v)
  );

  phy_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (st_q == ST_WAKE),
    .done  (timer_done)
  );

  phy_sleep_fsm #(.NUM_PORTS(NUM_PORTS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .dev_pstate  (dev_pstate),
    .all_idle    (&idle_v),
    .any_susp    (|susp_v),
    .port_int_en (port_int_en),
    .lps_req     (lps_req),
    .wake_evt_v  (wake_evt_v),
    .timer_done  (timer_done),
    .st_q        (st_q),
    .wake_notify (wake_notify),
    .wake_port   (wake_port)
  );

  always_comb begin
    clkgen_en     = 1'b1;
    ref_core_en   = 1'b1;
    ref_detect_en = '1;
    clk_ready     = 1'b0;
    unique case (st_q)
      ST_ACTIVE: clk_ready = 1'b1;
      ST_LOW: begin
        clkgen_en     = 1'b0;
        ref_core_en   = 1'b0;
        ref_detect_en = need_det_v;
      end
      ST_ULTRA: begin
        clkgen_en     = 1'b0;
        ref_core_en   = 1'b0;
        ref_detect_en = '0;
      end
      default: ;
    endcase
  end

  logic [CW-1:0] wait_cnt_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                  wait_cnt_q <= '0;
    else if (clk_ready || !clkgen_en) wait_cnt_q <= '0;
    else                              wait_cnt_q <= wait_cnt_q + 1'b1;
  end

  // R8
  restart_time_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(clk_ready) |-> (wait_cnt_q == CW'(WAKE_CYCLES)));
  // R4
  gated_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !clkgen_en |-> (!clk_ready && !ref_core_en));
  // R10
  wake_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (clkgen_en && !clk_ready) |=> clkgen_en);

endmodule

// File: tb/phy_sleep_ctrl_bench.sv
module phy_sleep_ctrl_bench;
  localparam int N = 3;
  localparam int W = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     dev_pstate;
  logic [2*N-1:0] port_state;
  logic           port_int_en, lps_req;
  logic [N-1:0]   bias_evt, disc_evt, conn_evt;
  logic           clkgen_en, ref_core_en, clk_ready, wake_notify;
  logic [N-1:0]   ref_detect_en, wake_port;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state: 0 active, 1 shallow, 2 deep, 3 waking
  int           m_st;
  int           m_cnt;
  bit           m_ntf;
  logic [N-1:0] m_port;

  always #5 clk = ~clk;

  phy_sleep_ctrl #(.NUM_PORTS(N), .WAKE_CYCLES(W)) u_phy_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_pstate(dev_pstate), .port_state(port_state),
    .port_int_en(port_int_en), .lps_req(lps_req), .bias_evt(bias_evt),
    .disc_evt(disc_evt), .conn_evt(conn_evt), .clkgen_en(clkgen_en),
    .ref_core_en(ref_core_en), .ref_detect_en(ref_detect_en), .clk_ready(clk_ready),
    .wake_notify(wake_notify), .wake_port(wake_port));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ps(int i);
    return port_state[2*i +: 2];
  endfunction

  function automatic bit may_sleep();
    bit ok = dev_pstate[1] && !lps_req;
    for (int i = 0; i < N; i++) if (ps(i) == 2'b00) ok = 0;
    return ok;
  endfunction

  function automatic bit deep_ok();
    bit ok = !port_int_en;
    for (int i = 0; i < N; i++) if (ps(i) == 2'b11) ok = 0;
    return ok;
  endfunction

  function automatic logic [N-1:0] qual_evt();
    logic [N-1:0] q = '0;
    for (int i = 0; i < N; i++)
      q[i] = ((ps(i) == 2'b11) && (bias_evt[i] || disc_evt[i])) ||
             ((ps(i) != 2'b10) && conn_evt[i]);
    return q;
  endfunction

  function automatic logic [N-1:0] need_det();
    logic [N-1:0] d;
    for (int i = 0; i < N; i++) d[i] = (ps(i) != 2'b10);
    return d;
  endfunction

  task automatic model_edge();
    logic [N-1:0] q = qual_evt();
    m_ntf  = 0;
    m_port = '0;
    case (m_st)
      0: if (may_sleep()) m_st = deep_ok() ? 2 : 1;
      1: begin
        if (lps_req || (|q)) begin m_st = 3; m_cnt = 0; end
        m_ntf  = |q;
        m_port = q;
      end
      2: if (lps_req) begin m_st = 3; m_cnt = 0; end
      default: if (m_cnt == W - 1) m_st = 0; else m_cnt++;
    endcase
  endtask

  task automatic compare(string tag);
    int e_gate = (m_st == 0 || m_st == 3) ? 1 : 0;
    int e_det  = (m_st == 1) ? int'(need_det()) : (m_st == 2) ? 0 : (1 << N) - 1;
    chk(tag, "clkgen_en", int'(clkgen_en), e_gate);
    chk(tag, "ref_core_en", int'(ref_core_en), e_gate);
    chk(tag, "ref_detect_en", int'(ref_detect_en), e_det);
    chk(tag, "clk_ready", int'(clk_ready), (m_st == 0) ? 1 : 0);
    chk(tag, "wake_notify", int'(wake_notify), int'(m_ntf));
    chk(tag, "wake_port", int'(wake_port), int'(m_port));
  endtask

  // inputs are already set at a falling edge; advance one clock and compare
  task automatic cyc(string tag);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    lps_req = 0; bias_evt = '0; disc_evt = '0; conn_evt = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; dev_pstate = 2'b00; port_state = '0; port_int_en = 0; quiet();
    m_st = 0; m_cnt = 0; m_ntf = 0; m_port = '0;
    repeat (3) @(negedge clk);
    // R11 outputs held by reset
    compare("R11");
    rst_n = 1;
    repeat (3) cyc("R11");

    // R1: all ports idle but D1
    dev_pstate = 2'b01; port_state = {2'b01, 2'b01, 2'b01};
    repeat (3) cyc("R1");
    // R2: D3 but port 0 in use
    dev_pstate = 2'b11; port_state = {2'b01, 2'b10, 2'b00};
    repeat (3) cyc("R2");
    // R3: deep tier, no suspended port, interrupt enable clear
    port_state = {2'b01, 2'b10, 2'b01};
    cyc("R3");
    chk("R3", "deep detect off", int'(ref_detect_en), 0);
    // R7: events ignored in deep tier
    conn_evt = 3'b001; bias_evt = 3'b111; disc_evt = 3'b111;
    repeat (2) cyc("R7");
    chk("R7", "still gated", int'(clkgen_en), 0);
    quiet();
    // R5 / R8: lps wake, no notify
    lps_req = 1;
    cyc("R5");
    chk("R5", "no notify on lps wake", int'(wake_notify), 0);
    lps_req = 0; port_int_en = 1;
    repeat (W - 1) cyc("R8");
    // R10: wake completes, then re-enter shallow tier
    cyc("R10");
    chk("R10", "ready after wake", int'(clk_ready), 1);
    cyc("R10");
    chk("R3", "shallow detect mask", int'(ref_detect_en), 3'b101);
    // R6: non-qualifying events
    conn_evt = 3'b010; bias_evt = 3'b101; disc_evt = 3'b100;
    repeat (2) cyc("R6");
    chk("R6", "ignored events keep sleep", int'(clkgen_en), 0);
    quiet();
    port_state = {2'b11, 2'b10, 2'b01};
    cyc("R6");
    // R9: bias on suspended port 2
    bias_evt = 3'b100;
    cyc("R9");
    chk("R9", "notify port", int'(wake_port), 3'b100);
    quiet();
    repeat (W + 2) cyc("R10");
    // R6: connection on non-disabled port 0
    conn_evt = 3'b001;
    cyc("R6");
    chk("R6", "conn wake notify", int'(wake_notify), 1);
    quiet();
    cyc("R9");
    chk("R9", "notify one cycle", int'(wake_notify), 0);
    repeat (W) cyc("R8");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      dev_pstate = ($urandom % 4 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
      for (int i = 0; i < N; i++)
        port_state[2*i +: 2] = ($urandom % 8 == 0) ? 2'b00 : 2'(1 + $urandom % 3);
      port_int_en = 1'($urandom % 2);
      lps_req     = ($urandom % 24 == 0);
      for (int i = 0; i < N; i++) begin
        bias_evt[i] = ($urandom % 10 == 0);
        disc_evt[i] = ($urandom % 10 == 0);
        conn_evt[i] = ($urandom % 10 == 0);
      end
      cyc("R4");
    end
    done = 1;
    finish_run();
  end

endmodule